// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block performs the fetch part of an instruction cycle as a chain of register transfers. Four registers are involved: a program counter, an address staging register that alone drives the memory address lines, a data staging register that alone receives the memory data lines, and an instruction register. Each fetch takes three equal steps of one clock each. In the first step the program counter is copied into the address register. In the second step memory is read through that address and, in parallel, the program counter advances by the instruction length. In the third step the data register is copied into the instruction register.

The block is used by pulsing a start request while it is idle. Three clocks later the fetched word is visible on the instruction output, and a one-clock completion flag is raised. If the start request is held high, fetches run back to back with no idle cycle. A synchronous reset loads the program counter from a reset vector input. Memory is expected to answer a read combinationally within the same clock.

Top module: `ifetch_seq`

## Requirements
- R1: While reset is high at a clock edge, the block returns to idle, the instruction output becomes 0, the done flag and read strobe are 0, and the program counter is loaded from the reset vector input.
- R2: In idle, a start request sampled high at a clock edge begins the first step in the following cycle; no read is issued during that first step.
- R3: The address output is driven only from the address register, which is loaded from the program counter at the end of the first step, so during the read step it equals the program counter value held before the fetch (for example binary 1100100 appears unchanged).
- R4: The read strobe is high for exactly one clock per fetch, the second cycle of the fetch, and low in every other cycle.
- R5: At the end of the read step the data register captures the memory data input.
- R6: At the end of the read step the program counter advances by the instruction length (default 1), wrapping modulo two to the power of the address width, so the next fetch after address all-ones reads address 0.
- R7: At the end of the third step the data register is copied to the instruction output, which then holds the word read two clocks earlier.
- R8: The done flag is high for exactly one clock, the cycle right after the third step.
- R9: With start held high, a new fetch begins in the cycle after the third step, giving one read every three clocks.
- R10: A start request while a fetch is in progress has no effect: no additional fetch follows once that fetch ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to begin a fetch |
| resetVec | input | AW | Program counter value loaded on reset |
| memAddr | output | AW | Memory address, driven from the address register |
| memRd | output | 1 | Read strobe, high during the read step |
| memData | input | DW | Read data returned by memory in the same cycle |
| instrOut | output | DW | Instruction register contents |
| fetchDone | output | 1 | One-clock pulse after a fetch completes |

## Verification
The bench goes after the program counter wrap at the top address, where a design that dropped the carry wrongly or used a wider counter would read an address other than 0 next. It holds start high to catch a sequencer that inserts an idle cycle or loses the pulse timing between fetches, and it pulses start mid-fetch, where a design that latched the request would run a spurious extra read. Reset in the middle of a read checks that a half-done fetch cannot complete or leave the strobe raised, and comparing the address in the read step with the reset vector exposes a design that reads from the program counter after its increment.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  // Sequencer phase: idle plus the three equal time units of a fetch.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_T2   = 2'd2,
    PH_T3   = 2'd3
  } phase_t;

  // Strobes from control to datapath, one per register transfer.
  typedef struct packed {
    logic loadMar;    // address register <= program counter
    logic loadMbr;    // data register <= memory data
    logic advancePc;  // program counter <= program counter + length
    logic loadIr;     // instruction register <= data register
  } xfer_t;

endpackage

// File: rtl/ifetch_ctrl.sv
module ifetch_ctrl
  import ifetch_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  startReq,
  output xfer_t xfer,
  output logic  memRd,
  output logic  fetchDone
);

  phase_t phase;
  phase_t phaseNext;
  logic   doneQ;

  // Next-phase logic: start is only looked at in idle and after t3.
  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (startReq) phaseNext = PH_T1;
      PH_T1:   phaseNext = PH_T2;
      PH_T2:   phaseNext = PH_T3;
      PH_T3:   phaseNext = startReq ? PH_T1 : PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      doneQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      doneQ <= (phase == PH_T3);
    end
  end

  // Transfer strobes decoded from the phase.
  always_comb begin
    xfer           = '0;
    xfer.loadMar   = (phase == PH_T1);
    xfer.loadMbr   = (phase == PH_T2);
    xfer.advancePc = (phase == PH_T2);
    xfer.loadIr    = (phase == PH_T3);
  end

  assign memRd     = (phase == PH_T2);
  assign fetchDone = doneQ;

  // R2: a start seen in idle opens t1 on the next clock
  a_r2_start_to_t1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && startReq) |=> (phase == PH_T1));

  // R4: the read strobe never lasts two cycles
  a_r4_read_single: assert property (@(posedge clk) disable iff (rst)
    memRd |=> !memRd);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    fetchDone |=> !fetchDone);

  // R10: once reading, the fetch always proceeds to t3 whatever start does
  a_r10_no_abort: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_T2) |=> (phase == PH_T3));

endmodule

// File: rtl/ifetch_dp.sv
module ifetch_dp
  import ifetch_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int INSTR_LEN = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] resetVec,
  input  xfer_t         xfer,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] instrOut
);

  localparam logic [AW-1:0] PC_STEP = AW'(INSTR_LEN);

  logic [AW-1:0] pc;
  logic [AW-1:0] mar;
  logic [DW-1:0] mbr;
  logic [DW-1:0] ir;

  // Program counter: reset vector on reset, stepped during the read step.
  always_ff @(posedge clk) begin
    if (rst)                 pc <= resetVec;
    else if (xfer.advancePc) pc <= pc + PC_STEP;
  end

  // Address register: sole driver of the address lines.
  always_ff @(posedge clk) begin
    if (rst)               mar <= '0;
    else if (xfer.loadMar) mar <= pc;
  end

  // Data register: sole receiver of the data lines.
  always_ff @(posedge clk) begin
    if (rst)               mbr <= '0;
    else if (xfer.loadMbr) mbr <= memData;
  end

  // Instruction register.
  always_ff @(posedge clk) begin
    if (rst)              ir <= '0;
    else if (xfer.loadIr) ir <= mbr;
  end

  assign memAddr  = mar;
  assign instrOut = ir;

  // R3: the address register moves only on its own strobe
  a_r3_mar_hold: assert property (@(posedge clk) disable iff (rst)
    !xfer.loadMar |=> $stable(mar));

  // R6: the counter holds outside the read step
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !xfer.advancePc |=> $stable(pc));

endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifetch_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int INSTR_LEN = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          startReq,
  input  logic [AW-1:0] resetVec,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  input  logic [DW-1:0] memData,
  output logic [DW-1:0] instrOut,
  output logic          fetchDone
);

  xfer_t xfer;

  ifetch_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .startReq  (startReq),
    .xfer      (xfer),
    .memRd     (memRd),
    .fetchDone (fetchDone)
  );

  ifetch_dp #(
    .AW        (AW),
    .DW        (DW),
    .INSTR_LEN (INSTR_LEN)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .resetVec (resetVec),
    .xfer     (xfer),
    .memData  (memData),
    .memAddr  (memAddr),
    .instrOut (instrOut)
  );

  // R7: on done, the instruction is the word returned two clocks earlier
  a_r7_instr_from_read: assert property (@(posedge clk) disable iff (rst)
    (fetchDone && $past(memRd, 2)) |-> (instrOut == $past(memData, 2)));

  // R5: done is always preceded by a read two clocks before
  a_r5_read_before_done: assert property (@(posedge clk) disable iff (rst)
    fetchDone |-> $past(memRd, 2));

endmodule

// File: tb/test_ifetch_seq.sv
`timescale 1ns/1ps
module test_ifetch_seq;

  localparam int AW = 16;
  localparam int DW = 16;

  // Each entry: {reset vector, expected address of the following fetch}
  localparam int NVEC = 6;
  localparam logic [31:0] VEC_TAB [NVEC] = '{
    {16'h0064, 16'h0065},
    {16'h0000, 16'h0001},
    {16'h1234, 16'h1235},
    {16'h00FE, 16'h00FF},
    {16'hFFFE, 16'hFFFF},
    {16'hFFFF, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          startReq = 1'b0;
  logic [AW-1:0] resetVec = '0;
  logic [AW-1:0] memAddr;
  logic          memRd;
  logic [DW-1:0] memData;
  logic [DW-1:0] instrOut;
  logic          fetchDone;

  logic [DW-1:0] mem [256];

  int testCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  assign memData = mem[memAddr[7:0]];

  ifetch_seq #(.AW(AW), .DW(DW), .INSTR_LEN(1)) i_ifetch_seq (
    .clk       (clk),
    .rst       (rst),
    .startReq  (startReq),
    .resetVec  (resetVec),
    .memAddr   (memAddr),
    .memRd     (memRd),
    .memData   (memData),
    .instrOut  (instrOut),
    .fetchDone (fetchDone)
  );

  function automatic logic [DW-1:0] wordAt(logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h31};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset(input logic [AW-1:0] vec);
    resetVec = vec;
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  // One fetch from idle, checking each time unit.
  task automatic oneFetch(input logic [AW-1:0] expAddr, input string tag);
    startReq = 1'b1;
    tick();                       // now in t1
    startReq = 1'b0;
    chk({"R2 no read in t1 ", tag}, 32'(memRd), 32'd0);
    tick();                       // now in t2
    chk({"R4 read in t2 ", tag}, 32'(memRd), 32'd1);
    chk({"R3 address in t2 ", tag}, 32'(memAddr), 32'(expAddr));
    tick();                       // now in t3
    chk({"R4 read low in t3 ", tag}, 32'(memRd), 32'd0);
    tick();                       // cycle after t3
    chk({"R8 done ", tag}, 32'(fetchDone), 32'd1);
    chk({"R5 R7 instr ", tag}, 32'(instrOut), 32'(wordAt(expAddr)));
    tick();
    chk({"R8 done drops ", tag}, 32'(fetchDone), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = wordAt(AW'(i));
  end

  initial begin
    #1000000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    // R1: reset state
    doReset(16'h0064);
    chk("R1 instr after reset", 32'(instrOut), 32'd0);
    chk("R1 done after reset", 32'(fetchDone), 32'd0);
    chk("R1 read after reset", 32'(memRd), 32'd0);

    // Table walk: fetch at reset vector, then the next one (R6 incl. wrap)
    for (int v = 0; v < NVEC; v++) begin
      doReset(VEC_TAB[v][31:16]);
      oneFetch(VEC_TAB[v][31:16], "vec");
      oneFetch(VEC_TAB[v][15:0], "R6 next");
    end

    // R9: start held high, back-to-back fetches
    doReset(16'h0010);
    startReq = 1'b1;
    tick();                       // t1
    tick();                       // t2
    chk("R9 first read", 32'(memRd), 32'd1);
    chk("R9 first addr", 32'(memAddr), 32'h10);
    tick();                       // t3
    tick();                       // done, t1 of next
    chk("R9 done first", 32'(fetchDone), 32'd1);
    chk("R9 instr first", 32'(instrOut), 32'(wordAt(16'h0010)));
    chk("R9 no read in gap", 32'(memRd), 32'd0);
    tick();                       // t2 of next
    chk("R9 second read", 32'(memRd), 32'd1);
    chk("R9 second addr", 32'(memAddr), 32'h11);
    startReq = 1'b0;
    tick();                       // t3
    tick();
    chk("R9 done second", 32'(fetchDone), 32'd1);
    chk("R9 instr second", 32'(instrOut), 32'(wordAt(16'h0011)));
    tick();

    // R10: start pulsed mid-fetch is ignored
    doReset(16'h0020);
    startReq = 1'b1;
    tick();                       // t1
    startReq = 1'b0;
    tick();                       // t2
    startReq = 1'b1;
    tick();                       // t3 (start sampled in t2: ignored)
    startReq = 1'b0;
    tick();                       // done, idle
    chk("R10 done", 32'(fetchDone), 32'd1);
    tick();
    chk("R10 no extra fetch t1", 32'(memRd), 32'd0);
    tick();
    chk("R10 no extra read", 32'(memRd), 32'd0);
    tick();
    chk("R10 no extra done", 32'(fetchDone), 32'd0);

    // R1: reset during the read step aborts the fetch
    doReset(16'h0030);
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    tick();                       // t2
    resetVec = 16'h0040;
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 read after mid reset", 32'(memRd), 32'd0);
    tick();
    chk("R1 no done after mid reset", 32'(fetchDone), 32'd0);
    oneFetch(16'h0040, "R1 after mid reset");

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule